// File: doc/BRIEF.md
# PRBS/QRSS Test Pattern Engine

This block is the per-channel test-pattern unit of a T1/E1/J1 line interface. It works on one serial bit per line clock. When its generator is switched on, it replaces the user's transmit bit stream with a maximal-length pseudo-random sequence. For E1 this is a 15-stage sequence of period 2^15-1. For T1/J1 it is a 20-stage quasi-random sequence whose runs of zeros are held to at most 14 bits.

The checker side takes the received stream and synchronises itself by loading the incoming bits into its own shift register. It then predicts each next bit and declares lock after an unbroken run of good compares. Lock is dropped when too many mismatches arrive inside one fixed window. A single saturating error counter is shared between three sources: pattern mismatches seen while locked, external bipolar-violation pulses and external excess-zero pulses.

A strobe copies the count into a holding register and restarts the counter in the same clock, so no event is lost. Generator and checker run independently, so a channel can send a pattern, check a pattern, or do both over a loop.

Top module: `prbs_qrss_engine`

## Requirements
- R1: After reset, `tx_data_out`, `locked` and `err_hold` are all 0.
- R2: With `gen_en` low, `tx_data_out` equals the `tx_data_in` value sampled one clock earlier.
- R3: With `gen_en` high and `mode_t1` = 0, the transmitted bits obey b[n] = b[n-14] XOR b[n-15] (x^15 + x^14 + 1), and the stream is not all zero.
- R4: With `mode_t1` = 1, the transmitted stream never has more than 14 zeros in a row. A checker looped back to the generator locks and counts no errors.
- R5: The checker does not lock before 32 consecutive error-free compares. On a clean looped-back stream it locks within 100 clocks of `chk_en` rising.
- R6: In E1 mode, while locked, a single inverted received bit adds exactly 3 to the pattern error count: the bit itself, plus its echoes at the 14th and 15th following bits.
- R7: While locked, 8 or more mismatches inside one aligned 64-bit window clear `locked`. After the errors stop, lock is regained.
- R8: While `locked` is 0, pattern mismatches are not counted.
- R9: `err_src` selects what the counter counts: 0 counts pattern errors while locked, 1 counts `bpv_evt` pulses, 2 counts `exz_evt` pulses, and 3 counts nothing.
- R10: The counter stops at 0xFFFF and does not wrap.
- R11: On `latch_stb`, `err_hold` takes the count of all events before that clock. The counter restarts at 1 if an event occurs in that same clock, and at 0 otherwise.
- R12: With `chk_en` low, `locked` is 0 from the next clock on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_t1 | input | 1 | 0: 15-stage PRBS (E1), 1: 20-stage QRSS (T1/J1) |
| gen_en | input | 1 | Replace transmit data with the pattern |
| chk_en | input | 1 | Enable the pattern checker |
| tx_data_in | input | 1 | User transmit bit |
| tx_data_out | output | 1 | Registered transmit bit |
| rx_data | input | 1 | Received bit |
| err_src | input | 2 | Counter source select |
| bpv_evt | input | 1 | Bipolar violation pulse |
| exz_evt | input | 1 | Excess-zero pulse |
| latch_stb | input | 1 | Copy counter to holding register and restart it |
| err_hold | output | CNT_W | Latched error count |
| locked | output | 1 | Checker pattern lock |

## Verification
The bench builds the block with its default parameters: a 16-bit counter, a lock run of 32, and a 64-bit window with an 8-error threshold. With these values, saturation is reached by one long stretch of 65,535 continuous violation pulses, well inside the run budget. A burst of 20 inverted bits is also certain to place at least 8 errors in one aligned window, wherever the window boundary falls. A loop from transmit to receive, with bit inversion injected by the bench, checks the lock, the error echo count and the loss of lock. A random received stream shows that nothing is counted while unlocked.

// File: rtl/prbs_qrss_engine.sv
module prbs_qrss_engine #(
  parameter int CNT_W     = 16,
  parameter int LOCK_RUN  = 32,
  parameter int LOSS_WIN  = 64,
  parameter int LOSS_ERRS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_t1,
  input  logic             gen_en,
  input  logic             chk_en,
  input  logic             tx_data_in,
  output logic             tx_data_out,
  input  logic             rx_data,
  input  logic [1:0]       err_src,
  input  logic             bpv_evt,
  input  logic             exz_evt,
  input  logic             latch_stb,
  output logic [CNT_W-1:0] err_hold,
  output logic             locked
);
  localparam int SR_W  = 20;
  localparam int RUN_W = $clog2(LOCK_RUN + 1);
  localparam int WIN_W = $clog2(LOSS_WIN);
  localparam int ERR_W = $clog2(LOSS_ERRS + 1);

  logic [SR_W-1:0]  gsr, csr;
  logic [RUN_W-1:0] run;
  logic [WIN_W-1:0] win;
  logic [ERR_W-1:0] werr;
  logic [CNT_W-1:0] cnt;

  wire g_raw   = mode_t1 ? (gsr[19] ^ gsr[16]) : (gsr[14] ^ gsr[13]);
  wire g_dead  = mode_t1 ? (gsr == '0) : (gsr[14:0] == '0);
  wire g_fb    = g_raw | g_dead;
  wire g_bit   = (mode_t1 && gsr[13:0] == '0) ? 1'b1 : g_fb;

  wire c_fb    = mode_t1 ? (csr[19] ^ csr[16]) : (csr[14] ^ csr[13]);
  wire c_force = mode_t1 && (csr[13:0] == '0);
  wire c_exp   = c_force | c_fb;
  wire c_in    = c_force ? c_fb : rx_data;
  wire c_err   = chk_en && (rx_data != c_exp);

  logic cnt_evt;
  always_comb begin
    case (err_src)
      2'd0:    cnt_evt = c_err & locked;
      2'd1:    cnt_evt = bpv_evt;
      2'd2:    cnt_evt = exz_evt;
      default: cnt_evt = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gsr         <= '1;
      tx_data_out <= 1'b0;
    end else begin
      if (gen_en) gsr <= {gsr[SR_W-2:0], g_fb};
      tx_data_out <= gen_en ? g_bit : tx_data_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      csr    <= '1;
      run    <= '0;
      win    <= '0;
      werr   <= '0;
      locked <= 1'b0;
    end else if (!chk_en) begin
      run    <= '0;
      win    <= '0;
      werr   <= '0;
      locked <= 1'b0;
    end else begin
      csr <= {csr[SR_W-2:0], c_in};
      if (!locked) begin
        if (c_err) begin
          run <= '0;
        end else if (run == RUN_W'(LOCK_RUN - 1)) begin
          run    <= '0;
          locked <= 1'b1;
          win    <= '0;
          werr   <= '0;
        end else begin
          run <= run + 1'b1;
        end
      end else begin
        if (c_err && (werr == ERR_W'(LOSS_ERRS - 1))) begin
          locked <= 1'b0;
          run    <= '0;
          win    <= '0;
          werr   <= '0;
        end else if (win == WIN_W'(LOSS_WIN - 1)) begin
          win  <= '0;
          werr <= '0;
        end else begin
          win  <= win + 1'b1;
          werr <= werr + ERR_W'(c_err);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      err_hold <= '0;
    end else if (latch_stb) begin
      err_hold <= cnt;
      cnt      <= CNT_W'(cnt_evt);
    end else if (cnt_evt && cnt != '1) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

module prbs_qrss_engine_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gen_en,
  input logic             chk_en,
  input logic             tx_data_in,
  input logic             tx_data_out,
  input logic             locked,
  input logic [1:0]       err_src,
  input logic             latch_stb,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] err_hold
);
  assert_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |=> tx_data_out == $past(tx_data_in));
  assert_latch_R11: assert property (@(posedge clk) disable iff (!rst_n)
    latch_stb |=> err_hold == $past(cnt));
  assert_no_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_stb |=> (cnt >= $past(cnt)) && ((cnt - $past(cnt)) <= 1));
  assert_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && err_src == 2'd0 && !latch_stb) |=> cnt == $past(cnt));
  assert_drop_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_en |=> !locked);
endmodule

bind prbs_qrss_engine prbs_qrss_engine_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .chk_en(chk_en),
  .tx_data_in(tx_data_in), .tx_data_out(tx_data_out), .locked(locked),
  .err_src(err_src), .latch_stb(latch_stb), .cnt(cnt), .err_hold(err_hold)
);

// File: tb/test_prbs_qrss_engine.sv
module test_prbs_qrss_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_t1 = 1'b0, gen_en = 1'b0, chk_en = 1'b0, tx_data_in = 1'b0;
  logic [1:0] err_src = 2'd0;
  logic bpv_evt = 1'b0, exz_evt = 1'b0, latch_stb = 1'b0;
  logic inj = 1'b0, use_noise = 1'b0, noise = 1'b0;
  logic tx_data_out, locked, rx_data;
  logic [15:0] err_hold;
  int tests = 0, fails = 0;
  bit done = 0;
  bit bits [0:1999];

  always #5 clk = ~clk;
  assign rx_data = use_noise ? noise : (tx_data_out ^ inj);

  prbs_qrss_engine i_prbs_qrss_engine (
    .clk(clk), .rst_n(rst_n), .mode_t1(mode_t1), .gen_en(gen_en),
    .chk_en(chk_en), .tx_data_in(tx_data_in), .tx_data_out(tx_data_out),
    .rx_data(rx_data), .err_src(err_src), .bpv_evt(bpv_evt),
    .exz_evt(exz_evt), .latch_stb(latch_stb), .err_hold(err_hold),
    .locked(locked));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_latch();
    latch_stb = 1'b1; tick(); latch_stb = 1'b0;
  endtask

  function automatic int max_zero_run(input int n);
    int r = 0, m = 0;
    for (int i = 0; i < n; i++) begin
      r = bits[i] ? 0 : r + 1;
      if (r > m) m = r;
    end
    return m;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int bad, ones, prev;
    void'($urandom(32'd2718));
    tick(3);
    check(tx_data_out == 0 && locked == 0 && err_hold == 0, "R1 reset",
          {tx_data_out, locked, err_hold}, 0);
    rst_n = 1'b1; tick();
    check(tx_data_out == 0 && locked == 0 && err_hold == 0, "R1 after release",
          {tx_data_out, locked, err_hold}, 0);

    bad = 0;
    for (int i = 0; i < 100; i++) begin
      prev = $urandom_range(0, 1);
      tx_data_in = prev[0]; tick();
      if (tx_data_out != prev[0]) bad++;
    end
    check(bad == 0, "R2 passthrough", bad, 0);

    mode_t1 = 1'b0; gen_en = 1'b1;
    for (int i = 0; i < 200; i++) begin tick(); bits[i] = tx_data_out; end
    bad = 0; ones = 0;
    for (int i = 0; i < 200; i++) begin
      ones += bits[i];
      if (i >= 15 && bits[i] != (bits[i-14] ^ bits[i-15])) bad++;
    end
    check(bad == 0, "R3 recurrence", bad, 0);
    check(ones > 0, "R3 nonzero", ones, 1);

    chk_en = 1'b1; tick(20);
    check(locked == 0, "R5 no early lock", locked, 0);
    tick(80);
    check(locked == 1, "R5 lock", locked, 1);

    do_latch();
    for (int k = 0; k < 5; k++) begin
      tick($urandom_range(40, 50));
      inj = 1'b1; tick(); inj = 1'b0;
    end
    tick(20); do_latch();
    check(err_hold == 15, "R6 three per flip", err_hold, 15);
    check(locked == 1, "R6 still locked", locked, 1);

    inj = 1'b1; tick(20); inj = 1'b0; tick(2);
    check(locked == 0, "R7 loss of lock", locked, 0);
    tick(150);
    check(locked == 1, "R7 relock", locked, 1);

    use_noise = 1'b1;
    for (int i = 0; i < 200; i++) begin noise = 1'($urandom_range(0, 1)); tick(); end
    do_latch();
    for (int i = 0; i < 300; i++) begin noise = 1'($urandom_range(0, 1)); tick(); end
    do_latch();
    check(err_hold == 0, "R8 unlocked not counted", err_hold, 0);
    check(locked == 0, "R8 unlocked", locked, 0);
    use_noise = 1'b0; tick(150);
    check(locked == 1, "R8 relock", locked, 1);

    chk_en = 1'b0; tick();
    check(locked == 0, "R12 disable", locked, 0);

    err_src = 2'd1; do_latch();
    for (int i = 0; i < 7; i++) begin bpv_evt = 1; tick(); bpv_evt = 0; tick(); end
    for (int i = 0; i < 3; i++) begin exz_evt = 1; tick(); exz_evt = 0; tick(); end
    do_latch();
    check(err_hold == 7, "R9 bpv source", err_hold, 7);
    err_src = 2'd2; do_latch();
    for (int i = 0; i < 7; i++) begin bpv_evt = 1; tick(); bpv_evt = 0; tick(); end
    for (int i = 0; i < 3; i++) begin exz_evt = 1; tick(); exz_evt = 0; tick(); end
    do_latch();
    check(err_hold == 3, "R9 exz source", err_hold, 3);
    err_src = 2'd3; do_latch();
    for (int i = 0; i < 4; i++) begin bpv_evt = 1; exz_evt = 1; tick(); end
    bpv_evt = 0; exz_evt = 0;
    do_latch();
    check(err_hold == 0, "R9 no source", err_hold, 0);

    err_src = 2'd1; bpv_evt = 1'b1;
    latch_stb = 1'b1; tick(); latch_stb = 1'b0; tick(36);
    latch_stb = 1'b1; tick(); latch_stb = 1'b0;
    check(err_hold == 37, "R11 no event lost", err_hold, 37);

    tick(70000); do_latch();
    check(err_hold == 16'hFFFF, "R10 saturation", err_hold, 16'hFFFF);
    bpv_evt = 1'b0;

    mode_t1 = 1'b1; tick(30);
    for (int i = 0; i < 2000; i++) begin tick(); bits[i] = tx_data_out; end
    check(max_zero_run(2000) <= 14, "R4 zero run", max_zero_run(2000), 14);
    err_src = 2'd0; chk_en = 1'b1; tick(100);
    check(locked == 1, "R4 qrss lock", locked, 1);
    do_latch(); tick(500); do_latch();
    check(err_hold == 0, "R4 qrss clean", err_hold, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule